// File: doc/BRIEF.md
# Slave Frame Timing Generator

This block sits at the remote end of a ping-pong digital subscriber link and rebuilds the local frame timing from the far end. It does not track the far end with a phase-locked loop. Each frame is anchored to the cycle in which the demodulator reports that a burst from the master has been fully received. From that point a counter running on the 2.048 MHz system clock walks through one 125 µs frame of 256 cycles. The counter produces the gated 16 kHz D-channel clock, two 8 kHz byte-enable windows and a bit clock inside those windows, and then stops with every output low.

Because the sequence restarts on every received burst and is idle between bursts, any drift between the two ends is absorbed once per frame. The block also times the start of the return burst, which comes a guard interval of eight baud periods after the received burst completes. One baud period is four system clocks. A power-down level suppresses the return burst. A tone-request input lets the local terminal side keep its clocks running while no bursts arrive.

Top module: `slave_frame_timer`

## Requirements
- R1: While reset is applied and after it is released, with no demodulation strobe and tone request low, every output is low.
- R2: A demodulation strobe sampled high on a clock edge makes the next cycle frame cycle 0. All timing is counted from that cycle.
- R3: The D-channel clock runs for exactly two periods of 128 cycles in each frame. It is high on frame cycles whose value modulo 128 is below 64, so it gives two rising edges per frame.
- R4: Byte enable bit 0 is high on frame cycles 0 to 63 and byte enable bit 1 is high on frame cycles 64 to 127. Each is high once per frame, and the two are never high together.
- R5: The bit clock is high only inside an enable window, on frame cycles below 128 whose value modulo 8 is below 4. This gives eight rising edges per window and sixteen per frame.
- R6: From frame cycle 256 onward, with no new strobe and tone request low, all clock and enable outputs stay low.
- R7: With power-up high, the transmit-start output pulses high for exactly one cycle on frame cycle 32, which is 8 bauds of 4 clocks after the strobe frame began.
- R8: With power-up low, the transmit-start output never goes high. A received burst still produces the full clock and enable sequence.
- R9: With tone request high and no burst running, the block starts frames by itself, back to back, every 256 cycles. These frames never raise transmit-start.
- R10: A demodulation strobe that arrives in the middle of a frame restarts the sequence, so the following cycle is frame cycle 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 2.048 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| demod_done_i | input | 1 | One-cycle strobe: a burst from the master finished demodulating |
| pwr_up_i | input | 1 | High when powered up; low suppresses the return burst |
| tone_req_i | input | 1 | High requests self-timed frames while no burst is running |
| dclk_o | output | 1 | Gated D-channel clock |
| byte_en_o | output | 2 | B-channel byte enables, bit 0 first window, bit 1 second |
| bit_clk_o | output | 1 | Bit clock inside the enable windows |
| tx_start_o | output | 1 | One-cycle strobe to start the return burst |

## Verification
The hardest situation to reach is a restart in the middle of a frame, because a second strobe has to land while the counter is deep in the enable windows. After the first strobe the bench waits a fixed 100 sampled cycles, issues the second strobe and then checks a full frame cycle by cycle from cycle 0. A stale count would show up as misplaced enables or a missing transmit pulse. Tone-driven frames are reached by raising the tone request while idle and watching more than one frame boundary, with no received burst.

// File: rtl/slv_timing_pkg.sv
package slv_timing_pkg;
    typedef enum logic [1:0] {
        SRC_IDLE  = 2'd0,
        SRC_BURST = 2'd1,
        SRC_TONE  = 2'd2
    } frame_src_e;
endpackage

// File: rtl/slv_frame_seq.sv
module slv_frame_seq
    import slv_timing_pkg::*;
#(
    parameter int FRAME_CLKS = 256,
    localparam int CW = $clog2(FRAME_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          demod_done,
    input  logic          tone_req,
    output frame_src_e    src,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

    typedef struct packed {
        frame_src_e    src;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (demod_done) begin
            seq_d.src = SRC_BURST;
            seq_d.cnt = '0;
        end else if (seq_q.src != SRC_IDLE) begin
            if (seq_q.cnt == LAST) begin
                seq_d.src = tone_req ? SRC_TONE : SRC_IDLE;
                seq_d.cnt = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end else if (tone_req) begin
            seq_d.src = SRC_TONE;
            seq_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{src: SRC_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign src = seq_q.src;
    assign cnt = seq_q.cnt;

    // R10: a strobe always lands the sequencer on a burst frame.
    assert_restart_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        demod_done |=> (src == SRC_BURST && cnt == '0));
endmodule

// File: rtl/slv_gate_decode.sv
module slv_gate_decode
    import slv_timing_pkg::*;
#(
    parameter int FRAME_CLKS    = 256,
    parameter int DCLK_CYCLES   = 2,
    parameter int NUM_EN        = 2,
    parameter int BITS_PER_BYTE = 8,
    parameter int CLKS_PER_BIT  = 8,
    parameter int CLKS_PER_BAUD = 4,
    parameter int GUARD_BAUDS   = 8,
    localparam int CW = $clog2(FRAME_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_src_e        src,
    input  logic [CW-1:0]     cnt,
    input  logic              pwr_up,
    output logic              dclk,
    output logic [NUM_EN-1:0] byte_en,
    output logic              bit_clk,
    output logic              tx_start
);
    localparam int DCLK_PER   = FRAME_CLKS / DCLK_CYCLES;
    localparam int EN_WIN     = BITS_PER_BYTE * CLKS_PER_BIT;
    localparam int GUARD_CLKS = GUARD_BAUDS * CLKS_PER_BAUD;

    localparam logic [CW:0] DCLK_P    = (CW+1)'(DCLK_PER);
    localparam logic [CW:0] DCLK_HALF = (CW+1)'(DCLK_PER / 2);
    localparam logic [CW:0] BIT_P     = (CW+1)'(CLKS_PER_BIT);
    localparam logic [CW:0] BIT_HALF  = (CW+1)'(CLKS_PER_BIT / 2);
    localparam logic [CW:0] EN_END    = (CW+1)'(NUM_EN * EN_WIN);
    localparam logic [CW:0] GUARD_AT  = (CW+1)'(GUARD_CLKS);

    logic        run;
    logic [CW:0] pos;

    always_comb begin
        run      = (src != SRC_IDLE);
        pos      = {1'b0, cnt};
        dclk     = run && ((pos % DCLK_P) < DCLK_HALF);
        bit_clk  = run && (pos < EN_END) && ((pos % BIT_P) < BIT_HALF);
        tx_start = (src == SRC_BURST) && (pos == GUARD_AT) && pwr_up;
    end

    for (genvar i = 0; i < NUM_EN; i++) begin : g_en
        localparam logic [CW:0] LO = (CW+1)'(i * EN_WIN);
        localparam logic [CW:0] HI = (CW+1)'((i + 1) * EN_WIN);
        assign byte_en[i] = run && (pos >= LO) && (pos < HI);
    end

    // R4: enable windows never overlap.
    assert_en_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(byte_en));
    // R5: bit clock only inside a window.
    assert_bclk_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_clk |-> (byte_en != '0));
endmodule

// File: rtl/slave_frame_timer.sv
module slave_frame_timer
    import slv_timing_pkg::*;
#(
    parameter int CLKS_PER_BAUD   = 4,
    parameter int BAUDS_PER_FRAME = 64,
    parameter int GUARD_BAUDS     = 8,
    parameter int DCLK_CYCLES     = 2,
    parameter int BITS_PER_BYTE   = 8,
    parameter int CLKS_PER_BIT    = 8,
    parameter int NUM_EN          = 2,
    localparam int FRAME_CLKS = CLKS_PER_BAUD * BAUDS_PER_FRAME,
    localparam int CW         = $clog2(FRAME_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              demod_done_i,
    input  logic              pwr_up_i,
    input  logic              tone_req_i,
    output logic              dclk_o,
    output logic [NUM_EN-1:0] byte_en_o,
    output logic              bit_clk_o,
    output logic              tx_start_o
);
    frame_src_e    src;
    logic [CW-1:0] cnt;

    slv_frame_seq #(
        .FRAME_CLKS(FRAME_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .demod_done (demod_done_i),
        .tone_req   (tone_req_i),
        .src        (src),
        .cnt        (cnt)
    );

    slv_gate_decode #(
        .FRAME_CLKS    (FRAME_CLKS),
        .DCLK_CYCLES   (DCLK_CYCLES),
        .NUM_EN        (NUM_EN),
        .BITS_PER_BYTE (BITS_PER_BYTE),
        .CLKS_PER_BIT  (CLKS_PER_BIT),
        .CLKS_PER_BAUD (CLKS_PER_BAUD),
        .GUARD_BAUDS   (GUARD_BAUDS)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .cnt      (cnt),
        .pwr_up   (pwr_up_i),
        .dclk     (dclk_o),
        .byte_en  (byte_en_o),
        .bit_clk  (bit_clk_o),
        .tx_start (tx_start_o)
    );

    // R8: no return burst while powered down.
    assert_tx_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |-> pwr_up_i);
    // R7: transmit start is a single-cycle pulse.
    assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |=> !tx_start_o);
    // R2: frame cycle 0 follows every strobe with clock, first enable and bit clock high.
    assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        demod_done_i |=> (dclk_o && byte_en_o[0] && bit_clk_o));
endmodule

// File: tb/slave_frame_timer_tb_top.sv
`timescale 1ns/1ps
module slave_frame_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       demod = 1'b0;
    logic       pwr_up = 1'b1;
    logic       tone = 1'b0;
    logic       dclk;
    logic [1:0] en;
    logic       bclk;
    logic       txs;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    slave_frame_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .demod_done_i (demod),
        .pwr_up_i     (pwr_up),
        .tone_req_i   (tone),
        .dclk_o       (dclk),
        .byte_en_o    (en),
        .bit_clk_o    (bclk),
        .tx_start_o   (txs)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe for one edge; returns at the negedge showing frame cycle 0.
    task automatic pulse_demod();
        @(negedge clk) demod = 1'b1;
        @(negedge clk) demod = 1'b0;
    endtask

    // Compare ncyc samples against the frame model; first sample is cycle 0.
    task automatic observe(input int ncyc, input bit exp_tx, input bit tone_mode,
                           input bit do_counts, input string tag);
        int md = 0, me = 0, mb = 0, mt = 0, mq = 0;
        int rd = 0, rb = 0, nt = 0;
        bit pd = 1'b0, pb = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            int  kk;
            bit  act, ed, eb, et;
            logic [1:0] ee;
            if (k > 0) @(negedge clk);
            kk  = tone_mode ? (k % 256) : k;
            act = tone_mode || (k < 256);
            ed  = act && ((kk % 128) < 64);
            ee  = {act && kk >= 64 && kk < 128, act && kk < 64};
            eb  = act && kk < 128 && ((kk % 8) < 4);
            et  = exp_tx && !tone_mode && (k == 32);
            if (dclk !== ed) md++;
            if (en !== ee) me++;
            if (bclk !== eb) mb++;
            if (txs !== et) mt++;
            if (!act && (dclk || en != 2'b00 || bclk)) mq++;
            if (dclk && !pd) rd++;
            if (bclk && !pb) rb++;
            if (txs) nt++;
            pd = dclk;
            pb = bclk;
        end
        check(md == 0, {tag, " R3 dclk mismatching cycles"}, md, 0);
        check(me == 0, {tag, " R4 enable mismatching cycles"}, me, 0);
        check(mb == 0, {tag, " R5 bit clock mismatching cycles"}, mb, 0);
        check(mt == 0, {tag, exp_tx ? " R7 tx cycle mismatches" : " R8 tx cycle mismatches"}, mt, 0);
        if (do_counts) begin
            check(rd == 2, {tag, " R3 dclk rising edges"}, rd, 2);
            check(rb == 16, {tag, " R5 bit clock rising edges"}, rb, 16);
            check(nt == (exp_tx ? 1 : 0), {tag, " R7 tx pulses"}, nt, exp_tx ? 1 : 0);
            check(mq == 0, {tag, " R6 activity after frame end"}, mq, 0);
        end
    endtask

    task automatic t_reset();
        int bad = 0;
        check({dclk, en, bclk, txs} == 5'b0, "R1 outputs during reset", int'({dclk, en, bclk, txs}), 0);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if ({dclk, en, bclk, txs} != 5'b0) bad++;
        end
        check(bad == 0, "R1 idle after reset", bad, 0);
    endtask

    task automatic t_normal();
        pwr_up = 1'b1;
        pulse_demod();
        check(dclk && en == 2'b01, "R2 frame cycle 0 after strobe", int'({dclk, en}), 5);
        observe(300, 1'b1, 1'b0, 1'b1, "normal");
    endtask

    task automatic t_powerdown();
        pwr_up = 1'b0;
        pulse_demod();
        observe(300, 1'b0, 1'b0, 1'b1, "powerdown R8");
        pwr_up = 1'b1;
    endtask

    task automatic t_restart();
        pulse_demod();
        observe(100, 1'b1, 1'b0, 1'b0, "pre-restart");
        pulse_demod();
        observe(300, 1'b1, 1'b0, 1'b1, "restart R10");
    endtask

    task automatic t_tone();
        int bad = 0;
        pwr_up = 1'b0;
        @(negedge clk) tone = 1'b1;
        @(negedge clk);
        observe(600, 1'b0, 1'b1, 1'b0, "tone R9");
        tone = 1'b0;
        // finish the running self-timed frame, then expect silence
        for (int i = 0; i < 300; i++) @(negedge clk);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if ({dclk, en, bclk, txs} != 5'b0) bad++;
        end
        check(bad == 0, "R9 quiet once tone request drops", bad, 0);
        pwr_up = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_normal();
        t_powerdown();
        t_restart();
        t_tone();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule